// File: doc/BRIEF.md
# Descriptor-chained serial DMA channel

This block is one DMA channel that carries bytes between a serial controller's buffer and system memory. A build parameter gives the channel its role, and that role fixes the direction. A receive channel takes bytes from the serial side and writes them to memory. A transmit channel reads memory and hands bytes to the serial side. Every data bus cycle moves one byte, carried in bits 7:0 of a 32-bit word. Only the memory address is driven, because the serial side is strobed directly.

The channel has two modes, selected when it starts. In counted mode it moves a programmed number of bytes from a programmed start address and then goes back to idle. In chained mode it walks a linked list of four-word descriptors in memory. It fills or drains each buffer in turn and writes status back into the descriptor. It stops when it meets a descriptor that software has not handed over, or when the chain pointer reaches a programmed boundary. Software can hand used descriptors back while the channel runs, so successive frames keep flowing.

Top module: `dmach_chan`

## Requirements
- R1: The four configuration registers are written only while the channel is idle; a write while busy is dropped. Selects: 0 start address, 1 byte count, 2 first descriptor pointer, 3 boundary pointer. A run begins only on a rising edge of `ch_en`, and `ch_chain` is sampled at that edge to choose the mode. A channel that has finished stays idle while `ch_en` remains high.
- R2: A data bus cycle is raised only after `ser_req` is seen high. Each granted data cycle moves exactly one byte, and `ser_ack` is high in exactly that grant cycle.
- R3: A receive channel (`IS_RX`=1) issues writes with `mem_wdata` = {24'b0, `ser_din`}. A transmit channel issues reads and presents `mem_rdata[7:0]` on `ser_dout`.
- R4: In counted mode, addresses rise by one per byte from the start address. After the programmed count the channel returns to idle. A count of 0 means 2^`CNT_W` bytes.
- R5: A descriptor is four 32-bit words at byte offsets +0 next pointer, +4 buffer address, +8 length (low `CNT_W` bits, 0 meaning 2^`CNT_W`), +12 status (bit 0 end-of-frame, bit 31 owned by DMA). The words are read in offset order.
- R6: After a buffer is done, chained mode moves on to the next pointer. It stops, idle and with no flag, when a fetched status word has bit 31 clear.
- R7: If the chain pointer equals the boundary register before a fetch, the channel goes idle and sets `bof_flag`. The flag clears at the next start.
- R8: On receive, a buffer ends when it is full or when a byte arrives with `ser_eof_in`. The channel then writes the byte count used to +8, then the status word to +12 with bit 31 = 0 and bit 0 = frame ended.
- R9: On transmit, `ser_eof_out` is high with the ack of the last byte of a buffer whose status bit 0 is set. The channel then writes +12 with bit 31 cleared and bit 0 kept.
- R10: With `ch_en` low, the channel completes any bus cycle already raised, goes idle, and issues no further requests.
- R11: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| ch_en | input | 1 | Channel enable; rising edge starts, low aborts |
| ch_chain | input | 1 | Mode at start: 1 chained, 0 counted |
| busy | output | 1 | Channel not idle |
| bof_flag | output | 1 | Chain reached the boundary pointer |
| mem_req | output | 1 | Memory bus request |
| mem_gnt | input | 1 | Memory bus grant; completes the cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| ser_req | input | 1 | Serial buffer has data (receive) or space (transmit) |
| ser_din | input | 8 | Byte from the serial receive buffer |
| ser_eof_in | input | 1 | Byte on ser_din closes a frame |
| ser_ack | output | 1 | One byte taken from or given to the serial side |
| ser_dout | output | 8 | Byte toward the serial transmit buffer |
| ser_eof_out | output | 1 | Byte on ser_dout closes a frame |

## Verification
The bench stalls the bus grant in a repeating pattern. A channel that let its address or direction drift while waiting would write to the wrong place, and the scoreboard would see it. A count of zero is driven to check that the counted run wraps to the full span; a design that treated zero as empty would stop at once. A receive frame that ends part way through a buffer checks that the written-back length is the count actually used and that the frame bit lands in the status word. A write to a register while busy, a finished run with enable still high, and an abort followed by a fresh request each check that the channel stays idle when it should. A design that restarted or kept moving data would produce writes the scoreboard does not expect. A chain is run into the boundary pointer and another into a descriptor that is not owned, to check that one stop raises the flag and the other does not.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    // descriptor word indexes (byte offset = index * 4)
    localparam logic [1:0] DW_NEXT = 2'd0;
    localparam logic [1:0] DW_BUF  = 2'd1;
    localparam logic [1:0] DW_LEN  = 2'd2;
    localparam logic [1:0] DW_STAT = 2'd3;

    localparam int STAT_EOF_BIT = 0;
    localparam int STAT_OWN_BIT = 31;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_DESC  = 2'd2,
        SEL_BOUND = 2'd3
    } cfg_sel_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SB_WAIT,
        S_SB_XFER,
        S_DCHK,
        S_DFETCH,
        S_CWAIT,
        S_CXFER,
        S_WBLEN,
        S_WBSTAT
    } eng_state_e;

    typedef enum logic [2:0] {
        CYC_NONE,
        CYC_DATA,
        CYC_DESC_RD,
        CYC_WB_LEN,
        CYC_WB_STAT
    } cyc_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] dptr;
        logic [WORD_W-1:0] bound;
    } chan_cfg_t;

    typedef struct packed {
        cyc_e              kind;
        logic [1:0]        widx;
        logic [WORD_W-1:0] data_addr;
        logic [WORD_W-1:0] dptr;
        logic [WORD_W-1:0] wb_len;
        logic              wb_eof;
    } bus_cmd_t;

    function automatic logic [WORD_W-1:0] desc_word_addr(
        input logic [WORD_W-1:0] base, input logic [1:0] idx);
        return base + {{(WORD_W-4){1'b0}}, idx, 2'b00};
    endfunction

    function automatic logic [WORD_W-1:0] released_status(input logic eof);
        logic [WORD_W-1:0] w;
        w = '0;
        w[STAT_EOF_BIT] = eof;
        w[STAT_OWN_BIT] = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              idle,
    output chan_cfg_t         cfg
);

    chan_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we && idle) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_ADDR:  cfg_q.addr  <= cfg_wdata;
                SEL_COUNT: cfg_q.count <= cfg_wdata;
                SEL_DESC:  cfg_q.dptr  <= cfg_wdata;
                SEL_BOUND: cfg_q.bound <= cfg_wdata;
                default:   cfg_q       <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg,
    input  logic              ch_en,
    input  logic              ch_chain,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              ser_req,
    input  logic              ser_eof_in,
    output logic              mem_req,
    output bus_cmd_t          cmd,
    output logic              ser_ack,
    output logic              ser_eof_out,
    output logic              busy,
    output logic              bof_flag
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    eng_state_e        st_q;
    logic              en_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] dptr_q;
    logic [WORD_W-1:0] next_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  used_q;
    logic [1:0]        widx_q;
    logic              desc_eof_q;
    logic              frame_eof_q;
    logic              bof_q;

    logic start, granted, last, data_cyc;

    assign start    = ch_en && !en_q;
    assign data_cyc = (st_q == S_SB_XFER) || (st_q == S_CXFER);
    assign granted  = mem_req && mem_gnt;
    assign last     = (remain_q == CNT_ONE);

    always_comb begin
        mem_req = 1'b0;
        cmd.kind = CYC_NONE;
        unique case (st_q)
            S_SB_XFER, S_CXFER: begin mem_req = 1'b1; cmd.kind = CYC_DATA;    end
            S_DFETCH:           begin mem_req = 1'b1; cmd.kind = CYC_DESC_RD; end
            S_WBLEN:            begin mem_req = 1'b1; cmd.kind = CYC_WB_LEN;  end
            S_WBSTAT:           begin mem_req = 1'b1; cmd.kind = CYC_WB_STAT; end
            default:            begin mem_req = 1'b0; cmd.kind = CYC_NONE;    end
        endcase
        cmd.widx      = widx_q;
        cmd.data_addr = addr_q;
        cmd.dptr      = dptr_q;
        cmd.wb_len    = {{(WORD_W-CNT_W){1'b0}}, used_q};
        cmd.wb_eof    = IS_RX ? frame_eof_q : desc_eof_q;
    end

    assign ser_ack     = granted && data_cyc;
    assign ser_eof_out = !IS_RX && ser_ack && (st_q == S_CXFER) && last && desc_eof_q;
    assign busy        = (st_q != S_IDLE);
    assign bof_flag    = bof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            en_q        <= 1'b0;
            addr_q      <= '0;
            dptr_q      <= '0;
            next_q      <= '0;
            remain_q    <= '0;
            used_q      <= '0;
            widx_q      <= '0;
            desc_eof_q  <= 1'b0;
            frame_eof_q <= 1'b0;
            bof_q       <= 1'b0;
        end else begin
            en_q <= ch_en;
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        bof_q <= 1'b0;
                        if (ch_chain) begin
                            dptr_q <= cfg.dptr;
                            st_q   <= S_DCHK;
                        end else begin
                            addr_q   <= cfg.addr;
                            remain_q <= cfg.count[CNT_W-1:0];
                            st_q     <= S_SB_WAIT;
                        end
                    end
                end
                S_SB_WAIT: begin
                    if (!ch_en)       st_q <= S_IDLE;
                    else if (ser_req) st_q <= S_SB_XFER;
                end
                S_SB_XFER: begin
                    if (granted) begin
                        addr_q   <= addr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                        st_q     <= (!ch_en || last) ? S_IDLE : S_SB_WAIT;
                    end
                end
                S_DCHK: begin
                    if (!ch_en) begin
                        st_q <= S_IDLE;
                    end else if (dptr_q == cfg.bound) begin
                        bof_q <= 1'b1;
                        st_q  <= S_IDLE;
                    end else begin
                        widx_q <= DW_NEXT;
                        st_q   <= S_DFETCH;
                    end
                end
                S_DFETCH: begin
                    if (granted) begin
                        widx_q      <= widx_q + 1'b1;
                        used_q      <= '0;
                        frame_eof_q <= 1'b0;
                        case (widx_q)
                            DW_NEXT: next_q     <= mem_rdata;
                            DW_BUF:  addr_q     <= mem_rdata;
                            DW_LEN:  remain_q   <= mem_rdata[CNT_W-1:0];
                            default: desc_eof_q <= mem_rdata[STAT_EOF_BIT];
                        endcase
                        if (!ch_en)
                            st_q <= S_IDLE;
                        else if (widx_q == DW_STAT)
                            st_q <= mem_rdata[STAT_OWN_BIT] ? S_CWAIT : S_IDLE;
                    end
                end
                S_CWAIT: begin
                    if (!ch_en)       st_q <= S_IDLE;
                    else if (ser_req) st_q <= S_CXFER;
                end
                S_CXFER: begin
                    if (granted) begin
                        addr_q   <= addr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                        used_q   <= used_q + 1'b1;
                        if (!ch_en) begin
                            st_q <= S_IDLE;
                        end else if (IS_RX) begin
                            if (ser_eof_in) begin
                                frame_eof_q <= 1'b1;
                                st_q        <= S_WBLEN;
                            end else begin
                                st_q <= last ? S_WBLEN : S_CWAIT;
                            end
                        end else begin
                            st_q <= last ? S_WBSTAT : S_CWAIT;
                        end
                    end
                end
                S_WBLEN: begin
                    if (granted) st_q <= ch_en ? S_WBSTAT : S_IDLE;
                end
                S_WBSTAT: begin
                    if (granted) begin
                        dptr_q <= next_q;
                        st_q   <= ch_en ? S_DCHK : S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmach_busmux.sv
module dmach_busmux
    import dmach_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input  bus_cmd_t          cmd,
    input  logic [BYTE_W-1:0] ser_din,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    logic              data_we;
    logic [WORD_W-1:0] data_wdata;

    generate
        if (IS_RX) begin : g_rx
            assign data_we    = 1'b1;
            assign data_wdata = {{(WORD_W-BYTE_W){1'b0}}, ser_din};
        end else begin : g_tx
            assign data_we    = 1'b0;
            assign data_wdata = '0;
        end
    endgenerate

    always_comb begin
        mem_addr  = cmd.data_addr;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (cmd.kind)
            CYC_DATA: begin
                mem_we    = data_we;
                mem_wdata = data_wdata;
            end
            CYC_DESC_RD: mem_addr = desc_word_addr(cmd.dptr, cmd.widx);
            CYC_WB_LEN: begin
                mem_addr  = desc_word_addr(cmd.dptr, DW_LEN);
                mem_we    = 1'b1;
                mem_wdata = cmd.wb_len;
            end
            CYC_WB_STAT: begin
                mem_addr  = desc_word_addr(cmd.dptr, DW_STAT);
                mem_we    = 1'b1;
                mem_wdata = released_status(cmd.wb_eof);
            end
            default: mem_addr = cmd.data_addr;
        endcase
    end

endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
    import dmach_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        ch_en,
    input  logic        ch_chain,
    output logic        busy,
    output logic        bof_flag,
    output logic        mem_req,
    input  logic        mem_gnt,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        ser_req,
    input  logic [7:0]  ser_din,
    input  logic        ser_eof_in,
    output logic        ser_ack,
    output logic [7:0]  ser_dout,
    output logic        ser_eof_out
);

    chan_cfg_t cfg;
    bus_cmd_t  cmd;

    dmach_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .idle      (!busy),
        .cfg       (cfg)
    );

    dmach_engine #(.IS_RX(IS_RX), .CNT_W(CNT_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .ch_en       (ch_en),
        .ch_chain    (ch_chain),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .ser_req     (ser_req),
        .ser_eof_in  (ser_eof_in),
        .mem_req     (mem_req),
        .cmd         (cmd),
        .ser_ack     (ser_ack),
        .ser_eof_out (ser_eof_out),
        .busy        (busy),
        .bof_flag    (bof_flag)
    );

    dmach_busmux #(.IS_RX(IS_RX)) u_busmux (
        .cmd       (cmd),
        .ser_din   (ser_din),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign ser_dout = mem_rdata[BYTE_W-1:0];

endmodule

// File: rtl/dmach_chan_chk.sv
module dmach_chan_chk
    import dmach_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        ch_en,
    input logic        busy,
    input logic        bof_flag,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        ser_ack,
    input logic        ser_eof_out,
    input chan_cfg_t   cfg
);

    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    p_ack_on_grant_r2: assert property (@(posedge clk) disable iff (rst)
        ser_ack |-> (mem_req && mem_gnt));

    p_dir_r3: assert property (@(posedge clk) disable iff (rst)
        ser_ack |-> (mem_we == IS_RX));

    p_bof_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bof_flag) |-> !busy);

    p_eof_with_ack_r9: assert property (@(posedge clk) disable iff (rst)
        ser_eof_out |-> ser_ack);

    p_abort_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (!ch_en && !mem_req) |=> !busy);

    p_abort_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (!ch_en && mem_req && mem_gnt) |=> !busy);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind dmach_chan dmach_chan_chk #(.IS_RX(IS_RX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch_en       (ch_en),
    .busy        (busy),
    .bof_flag    (bof_flag),
    .mem_req     (mem_req),
    .mem_gnt     (mem_gnt),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .ser_ack     (ser_ack),
    .ser_eof_out (ser_eof_out),
    .cfg         (cfg)
);

// File: tb/dmach_chan_tb.sv
module dmach_chan_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int gcnt  = 0;

    // receive-role channel signals
    logic        r_cfg_we = 0, r_en = 0, r_chain = 0, r_gnt = 0;
    logic [1:0]  r_cfg_sel = 0;
    logic [31:0] r_cfg_wdata = 0, r_rdata = 0;
    logic        r_ser_req = 0, r_ser_eof_in = 0;
    logic [7:0]  r_ser_din = 0;
    logic        r_busy, r_bof, r_req, r_we, r_ack, r_eof_out;
    logic [31:0] r_addr, r_wdata;
    logic [7:0]  r_dout;

    // transmit-role channel signals
    logic        t_cfg_we = 0, t_en = 0, t_chain = 0, t_gnt = 0;
    logic [1:0]  t_cfg_sel = 0;
    logic [31:0] t_cfg_wdata = 0, t_rdata = 0;
    logic        t_ser_req = 0;
    logic        t_busy, t_bof, t_req, t_we, t_ack, t_eof_out;
    logic [31:0] t_addr, t_wdata;
    logic [7:0]  t_dout;

    dmach_chan #(.IS_RX(1'b1), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(r_cfg_we), .cfg_sel(r_cfg_sel), .cfg_wdata(r_cfg_wdata),
        .ch_en(r_en), .ch_chain(r_chain), .busy(r_busy), .bof_flag(r_bof),
        .mem_req(r_req), .mem_gnt(r_gnt), .mem_we(r_we), .mem_addr(r_addr),
        .mem_wdata(r_wdata), .mem_rdata(r_rdata), .ser_req(r_ser_req), .ser_din(r_ser_din),
        .ser_eof_in(r_ser_eof_in), .ser_ack(r_ack), .ser_dout(r_dout), .ser_eof_out(r_eof_out));

    dmach_chan #(.IS_RX(1'b0), .CNT_W(CW)) u_dut_tx (
        .clk(clk), .rst(rst), .cfg_we(t_cfg_we), .cfg_sel(t_cfg_sel), .cfg_wdata(t_cfg_wdata),
        .ch_en(t_en), .ch_chain(t_chain), .busy(t_busy), .bof_flag(t_bof),
        .mem_req(t_req), .mem_gnt(t_gnt), .mem_we(t_we), .mem_addr(t_addr),
        .mem_wdata(t_wdata), .mem_rdata(t_rdata), .ser_req(t_ser_req), .ser_din(8'h00),
        .ser_eof_in(1'b0), .ser_ack(t_ack), .ser_dout(t_dout), .ser_eof_out(t_eof_out));

    // memory model, stimulus queues and scoreboards
    logic [31:0] mem [logic [31:0]];
    logic [8:0]  rx_src[$];          // {eof, byte}
    logic [63:0] rx_wexp[$];         // {addr, data}
    logic [63:0] tx_wexp[$];
    logic [8:0]  tx_sexp[$];         // {eof, byte}
    logic        rx_pop = 0;
    logic        tx_space = 0;
    logic        r_wait = 0, t_wait = 0;
    logic [31:0] r_wait_addr = 0, t_wait_addr = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        gcnt++;
        if (rx_pop) begin
            void'(rx_src.pop_front());
            rx_pop = 1'b0;
        end
        r_ser_req = (rx_src.size() != 0);
        {r_ser_eof_in, r_ser_din} = r_ser_req ? rx_src[0] : 9'h0;
        t_ser_req = tx_space;
        r_gnt = 1'b0;
        t_gnt = 1'b0;
        #1;
        // R11: a stalled request must be held with the same address
        if (r_wait) check("R11 rx hold", {31'b0, r_req, r_addr}, {31'b0, 1'b1, r_wait_addr});
        if (t_wait) check("R11 tx hold", {31'b0, t_req, t_addr}, {31'b0, 1'b1, t_wait_addr});
        r_wait = 1'b0;
        t_wait = 1'b0;
        if (r_req && !rst) begin
            if ((gcnt % 3) != 0) begin
                r_gnt = 1'b1;
                if (r_we) begin
                    mem[r_addr] = r_wdata;
                    if (rx_wexp.size() == 0) check("R2 rx unexpected write", {r_addr, r_wdata}, 64'h0);
                    else check("R8 rx write", {r_addr, r_wdata}, rx_wexp.pop_front());
                end else r_rdata = mrd(r_addr);
            end else begin
                r_wait = 1'b1;
                r_wait_addr = r_addr;
            end
        end
        if (t_req && !rst) begin
            if ((gcnt % 4) != 1) begin
                t_gnt = 1'b1;
                if (t_we) begin
                    mem[t_addr] = t_wdata;
                    if (tx_wexp.size() == 0) check("R9 tx unexpected write", {t_addr, t_wdata}, 64'h0);
                    else check("R9 tx write", {t_addr, t_wdata}, tx_wexp.pop_front());
                end else t_rdata = mrd(t_addr);
            end else begin
                t_wait = 1'b1;
                t_wait_addr = t_addr;
            end
        end
        #1;
        if (r_ack) rx_pop = 1'b1;
        if (t_ack) begin
            if (tx_sexp.size() == 0) check("R3 tx unexpected byte", {55'b0, t_eof_out, t_dout}, 64'h0);
            else check("R3 tx byte", {55'b0, t_eof_out, t_dout}, {55'b0, tx_sexp.pop_front()});
        end
    end

    task automatic rx_cfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); r_cfg_we = 1; r_cfg_sel = sel; r_cfg_wdata = d;
        @(negedge clk); r_cfg_we = 0;
    endtask

    task automatic tx_cfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); t_cfg_we = 1; t_cfg_sel = sel; t_cfg_wdata = d;
        @(negedge clk); t_cfg_we = 0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rx_src.size() == 0 && rx_wexp.size() == 0 && tx_wexp.size() == 0 &&
                tx_sexp.size() == 0 && !r_busy && !t_busy) break;
        end
        check({req, " queues drained"},
              {32'(rx_src.size() + rx_wexp.size()), 32'(tx_wexp.size() + tx_sexp.size())}, 64'h0);
        check({req, " idle"}, {62'b0, r_busy, t_busy}, 64'h0);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] buf_a,
                            input logic [31:0] len, input logic [31:0] stat);
        mem[a] = nxt; mem[a+4] = buf_a; mem[a+8] = len; mem[a+12] = stat;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        check("R1 reset outputs", {58'b0, r_busy, r_bof, r_req, r_ack, t_busy, t_req}, 64'h0);

        // R2/R4: counted receive, waits for request, ignores writes while busy
        rx_cfg(2'd0, 32'h1000);
        rx_cfg(2'd1, 32'd5);
        @(negedge clk); r_en = 1; r_chain = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2 no request before ser_req", {63'b0, r_req}, 64'h0);
        end
        rx_cfg(2'd0, 32'h9000);   // R1: dropped, channel busy
        for (int i = 0; i < 5; i++) begin
            rx_src.push_back({1'b0, 8'hA0 + 8'(i)});
            rx_wexp.push_back({32'h1000 + 32'(i), 32'h0000_00A0 + 32'(i)});
        end
        drain("R4 counted rx");
        // R1: enable still high, finished channel must not restart
        repeat (4) @(negedge clk);
        check("R1 no restart while enabled", {63'b0, r_busy}, 64'h0);
        @(negedge clk); r_en = 0;

        // R1: start address register kept its idle value
        rx_cfg(2'd1, 32'd3);
        @(negedge clk); r_en = 1;
        for (int i = 0; i < 3; i++) begin
            rx_src.push_back({1'b0, 8'h30 + 8'(i)});
            rx_wexp.push_back({32'h1000 + 32'(i), 32'h0000_0030 + 32'(i)});
        end
        drain("R1 busy write dropped");
        @(negedge clk); r_en = 0;

        // R4: count 0 means 2^CNT_W bytes
        rx_cfg(2'd0, 32'h1100);
        rx_cfg(2'd1, 32'd0);
        @(negedge clk); r_en = 1;
        for (int i = 0; i < (1 << CW); i++) begin
            rx_src.push_back({1'b0, 8'h40 + 8'(i)});
            rx_wexp.push_back({32'h1100 + 32'(i), 32'h0000_0040 + 32'(i)});
        end
        drain("R4 zero count wraps");
        @(negedge clk); r_en = 0;

        // R10: abort in the middle of a counted run
        rx_cfg(2'd0, 32'h1200);
        rx_cfg(2'd1, 32'd10);
        @(negedge clk); r_en = 1;
        for (int i = 0; i < 3; i++) begin
            rx_src.push_back({1'b0, 8'h60 + 8'(i)});
            rx_wexp.push_back({32'h1200 + 32'(i), 32'h0000_0060 + 32'(i)});
        end
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (rx_src.size() == 0 && rx_wexp.size() == 0) break;
        end
        r_en = 0;
        repeat (2) @(negedge clk);
        check("R10 abort idle", {63'b0, r_busy}, 64'h0);
        rx_src.push_back({1'b0, 8'h77});
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R10 no request after abort", {63'b0, r_req}, 64'h0);
        end
        rx_src.delete();
        @(negedge clk);

        // R5/R6/R8: chained receive, buffer fill then early frame end
        put_desc(32'h100, 32'h110, 32'h2000, 32'd4, 32'h8000_0000);
        put_desc(32'h110, 32'h120, 32'h3000, 32'd8, 32'h8000_0000);
        put_desc(32'h120, 32'h130, 32'h3800, 32'd8, 32'h0000_0000);
        rx_cfg(2'd2, 32'h100);
        rx_cfg(2'd3, 32'h200);
        @(negedge clk); r_chain = 1; r_en = 1;
        for (int i = 0; i < 4; i++) begin
            rx_src.push_back({1'b0, 8'h10 + 8'(i)});
            rx_wexp.push_back({32'h2000 + 32'(i), 32'h0000_0010 + 32'(i)});
        end
        rx_wexp.push_back({32'h108, 32'd4});
        rx_wexp.push_back({32'h10C, 32'h0});
        for (int i = 0; i < 3; i++) begin
            rx_src.push_back({(i == 2), 8'h20 + 8'(i)});
            rx_wexp.push_back({32'h3000 + 32'(i), 32'h0000_0020 + 32'(i)});
        end
        rx_wexp.push_back({32'h118, 32'd3});
        rx_wexp.push_back({32'h11C, 32'h1});
        drain("R8 chain rx");
        check("R6 not-owned stop leaves flag clear", {63'b0, r_bof}, 64'h0);
        @(negedge clk); r_en = 0;

        // R7: chain reaches the boundary pointer
        put_desc(32'h180, 32'h190, 32'h2100, 32'd2, 32'h8000_0000);
        rx_cfg(2'd2, 32'h180);
        rx_cfg(2'd3, 32'h190);
        @(negedge clk); r_en = 1;
        for (int i = 0; i < 2; i++) begin
            rx_src.push_back({1'b0, 8'h50 + 8'(i)});
            rx_wexp.push_back({32'h2100 + 32'(i), 32'h0000_0050 + 32'(i)});
        end
        rx_wexp.push_back({32'h188, 32'd2});
        rx_wexp.push_back({32'h18C, 32'h0});
        drain("R7 boundary");
        check("R7 boundary flag set", {63'b0, r_bof}, 64'h1);
        @(negedge clk); r_en = 0;
        rx_cfg(2'd0, 32'h1300);
        rx_cfg(2'd1, 32'd1);
        @(negedge clk); r_chain = 0; r_en = 1;
        repeat (2) @(negedge clk);
        check("R7 flag cleared at start", {63'b0, r_bof}, 64'h0);
        rx_src.push_back({1'b0, 8'h99});
        rx_wexp.push_back({32'h1300, 32'h99});
        drain("R7 follow-up run");
        @(negedge clk); r_en = 0;

        // R2/R3: counted transmit waits for space, low byte only
        for (int i = 0; i < 3; i++) mem[32'h4000 + 32'(i)] = {24'hABCDEF, 8'h55 + 8'(i)};
        tx_cfg(2'd0, 32'h4000);
        tx_cfg(2'd1, 32'd3);
        @(negedge clk); t_chain = 0; t_en = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2 tx waits for space", {63'b0, t_req}, 64'h0);
        end
        for (int i = 0; i < 3; i++) tx_sexp.push_back({1'b0, 8'h55 + 8'(i)});
        tx_space = 1;
        drain("R3 counted tx");
        @(negedge clk); t_en = 0;

        // R9: chained transmit with frame end on the second buffer
        for (int i = 0; i < 2; i++) mem[32'h5000 + 32'(i)] = 32'h0000_00C0 + 32'(i);
        for (int i = 0; i < 3; i++) mem[32'h6000 + 32'(i)] = 32'h0000_00D0 + 32'(i);
        put_desc(32'h500, 32'h510, 32'h5000, 32'd2, 32'h8000_0000);
        put_desc(32'h510, 32'h520, 32'h6000, 32'd3, 32'h8000_0001);
        put_desc(32'h520, 32'h530, 32'h7000, 32'd3, 32'h0000_0000);
        tx_cfg(2'd2, 32'h500);
        tx_cfg(2'd3, 32'hFF0);
        for (int i = 0; i < 2; i++) tx_sexp.push_back({1'b0, 8'hC0 + 8'(i)});
        tx_wexp.push_back({32'h50C, 32'h0});
        for (int i = 0; i < 3; i++) tx_sexp.push_back({(i == 2), 8'hD0 + 8'(i)});
        tx_wexp.push_back({32'h51C, 32'h1});
        @(negedge clk); t_chain = 1; t_en = 1;
        drain("R9 chain tx");
        check("R6 tx stop without flag", {63'b0, t_bof}, 64'h0);
        @(negedge clk); t_en = 0;

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule